// File: doc/BRIEF.md
# Static memory read strobe sequencer

This block turns single read requests into timed read cycles on an external static memory bus. A request names an address and one of several chip selects. The block places the address on the bus and holds it for the whole cycle. It drives the active-low chip select of the addressed device and an active-low read strobe. It captures the returned data word and hands it back with a one-clock acknowledge.

Each chip select keeps its own timing set, counted in whole clock cycles. The set holds a setup delay and a pulse width for the read strobe, the same pair for the chip select, and a total cycle length. Hold times are not programmed. Each one is whatever remains of the total length after that strobe's setup and pulse. If the programmed length is shorter than a strobe's setup plus pulse, the cycle is stretched to fit.

A requester offers a request while the ready output is high. Ready is high when the block is idle and also in the last clock of a running cycle. A new read can therefore start directly after the current one. When setup and hold are both zero, the strobes stay low without a break across such back-to-back reads.

Top module: `smc_rd_seq`

## Requirements
- R1: After reset, and whenever no read cycle is running, every chip select output and the read strobe are high (deasserted), the acknowledge is low and ready is high.
- R2: A read cycle accepted at a clock edge lasts L clocks, where L = max(cycle, rd_setup + rd_pulse, cs_setup + cs_pulse) of its chip select. Ready is high in the L-th clock and low in the clocks before it.
- R3: Counting the cycle's clocks from 0, the read strobe is low exactly in the clocks n with rd_setup <= n < rd_setup + rd_pulse.
- R4: Only the chip select output whose bit index equals the request's chip select goes low, exactly in the clocks n with cs_setup <= n < cs_setup + cs_pulse. All other chip select outputs stay high.
- R5: The address output takes the request's address at the accepting edge and does not change until the next accepting edge.
- R6: Read data is sampled from the data input at the clock edge that ends clock n = rd_setup + rd_pulse - 1 of the cycle. The acknowledge is high for exactly the one clock after the cycle's last clock, and it carries the sampled word on the data output.
- R7: Each chip select has its own timing set. A configuration write changes only the set selected by its index. A pulse width written as 0 is stored as 1.
- R8: A read uses the timing set as it stood before its accepting edge. A configuration write that lands during a running read does not alter that read.
- R9: In back-to-back reads to one chip select, a request accepted in the last clock of a cycle starts the next cycle at once. With zero setup and no hold, the read strobe and chip select stay low with no high clock between the cycles.
- R10: A programmed cycle length shorter than a strobe's setup plus pulse is stretched to the larger sum, so no strobe window is cut short.
- R11: A request offered while ready is low is not taken. It is accepted only at an edge where ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing register write enable |
| cfg_cs_i | input | 2 | Chip select whose timing set is written |
| cfg_rd_setup_i | input | 6 | Read strobe setup, clocks |
| cfg_rd_pulse_i | input | 6 | Read strobe pulse, clocks (0 stored as 1) |
| cfg_cs_setup_i | input | 6 | Chip select setup, clocks |
| cfg_cs_pulse_i | input | 6 | Chip select pulse, clocks (0 stored as 1) |
| cfg_cycle_i | input | 7 | Total read cycle length, clocks |
| req_i | input | 1 | Read request valid |
| req_cs_i | input | 2 | Chip select of the request |
| req_addr_i | input | 24 | Address of the request |
| req_rdy_o | output | 1 | Request is taken at this edge when high |
| mem_addr_o | output | 24 | External address bus |
| mem_ncs_o | output | 4 | Chip selects, active low, one bit per device |
| mem_nrd_o | output | 1 | Read strobe, active low |
| mem_data_i | input | 32 | Read data from memory |
| rd_ack_o | output | 1 | One-clock read completion pulse |
| rd_data_o | output | 32 | Captured read data, valid with rd_ack_o |

## Verification
The bench drives a fresh random word on the data bus every clock. A capture one edge early or late therefore returns the wrong word instead of passing by accident. It also drives zero-setup, zero-hold bursts where ready rises in the last clock. A design that missed the same-clock restart would show a high strobe clock between reads. A design that accepted requests early would skip or duplicate reads. Timing sets whose cycle length is below setup plus pulse are included, as are pulse widths written as zero. A design that did not stretch such a cycle would cut the strobe window short or leave it stuck low. A design that did not clamp a zero pulse would never assert a strobe. Configuration writes land in the middle of reads to show whether the design latches timing at acceptance.

// File: rtl/smc_rd_pkg.sv
package smc_rd_pkg;

  localparam int SETUP_W = 6;
  localparam int PULSE_W = 6;
  localparam int CYCLE_W = 7;
  localparam int SUM_W   = ((SETUP_W > PULSE_W) ? SETUP_W : PULSE_W) + 1;
  localparam int LEN_W   = (CYCLE_W > SUM_W) ? CYCLE_W : SUM_W;

  typedef struct packed {
    logic [SETUP_W-1:0] rd_setup;
    logic [PULSE_W-1:0] rd_pulse;
    logic [SETUP_W-1:0] cs_setup;
    logic [PULSE_W-1:0] cs_pulse;
    logic [CYCLE_W-1:0] cycle;
  } rd_timing_t;

  function automatic logic [LEN_W-1:0] eff_len(rd_timing_t t);
    logic [LEN_W-1:0] s_rd, s_cs, cyc, m;
    s_rd = LEN_W'(t.rd_setup) + LEN_W'(t.rd_pulse);
    s_cs = LEN_W'(t.cs_setup) + LEN_W'(t.cs_pulse);
    cyc  = LEN_W'(t.cycle);
    m    = (s_rd > s_cs) ? s_rd : s_cs;
    m    = (cyc > m) ? cyc : m;
    if (m == '0) m = LEN_W'(1);
    return m;
  endfunction

endpackage

// File: rtl/smc_rd_cfg_bank.sv
module smc_rd_cfg_bank
  import smc_rd_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  rd_timing_t       wr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output rd_timing_t       rd_o
);

  rd_timing_t regs_q [NUM_CS];
  rd_timing_t wr_clamped;

  always_comb begin
    wr_clamped = wr_i;
    if (wr_i.rd_pulse == '0) wr_clamped.rd_pulse = PULSE_W'(1);
    if (wr_i.cs_pulse == '0) wr_clamped.cs_pulse = PULSE_W'(1);
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g].rd_setup <= '0;
        regs_q[g].rd_pulse <= PULSE_W'(1);
        regs_q[g].cs_setup <= '0;
        regs_q[g].cs_pulse <= PULSE_W'(1);
        regs_q[g].cycle    <= CYCLE_W'(1);
      end else if (we_i && (wr_idx_i == IDX_W'(g))) begin
        regs_q[g] <= wr_clamped;
      end
    end
  end

  assign rd_o = regs_q[rd_idx_i];

endmodule

// File: rtl/smc_rd_timer.sv
module smc_rd_timer
  import smc_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             act_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             last_o
);

  logic             act_q;
  logic [LEN_W-1:0] cnt_q;

  assign last_o = act_q && (cnt_q == len_i - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (last_o) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign act_o = act_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/smc_rd_window.sv
module smc_rd_window
  import smc_rd_pkg::*;
(
  input  logic               en_i,
  input  logic [LEN_W-1:0]   cnt_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic [PULSE_W-1:0] pulse_i,
  output logic               on_o,
  output logic               end_o
);

  logic [LEN_W:0] lo, hi, c;

  assign c     = {1'b0, cnt_i};
  assign lo    = (LEN_W+1)'(setup_i);
  assign hi    = lo + (LEN_W+1)'(pulse_i);
  assign on_o  = en_i && (c >= lo) && (c < hi);
  // final clock of the window: edge after it deasserts the strobe
  assign end_o = en_i && (c + (LEN_W+1)'(1) == hi);

endmodule

// File: rtl/smc_rd_seq.sv
module smc_rd_seq
  import smc_rd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_cs_i,
  input  logic [SETUP_W-1:0] cfg_rd_setup_i,
  input  logic [PULSE_W-1:0] cfg_rd_pulse_i,
  input  logic [SETUP_W-1:0] cfg_cs_setup_i,
  input  logic [PULSE_W-1:0] cfg_cs_pulse_i,
  input  logic [CYCLE_W-1:0] cfg_cycle_i,
  input  logic               req_i,
  input  logic [IDX_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               req_rdy_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [NUM_CS-1:0]  mem_ncs_o,
  output logic               mem_nrd_o,
  input  logic [DATA_W-1:0]  mem_data_i,
  output logic               rd_ack_o,
  output logic [DATA_W-1:0]  rd_data_o
);

  rd_timing_t       cfg_wr, cfg_sel, cur_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic             accept;
  logic             tmr_act, tmr_last;
  logic [LEN_W-1:0] tmr_cnt;
  logic             rd_on, rd_end, cs_on, cs_end;
  logic [DATA_W-1:0] cap_q, data_q;
  logic             ack_q;

  assign cfg_wr = '{rd_setup: cfg_rd_setup_i, rd_pulse: cfg_rd_pulse_i,
                    cs_setup: cfg_cs_setup_i, cs_pulse: cfg_cs_pulse_i,
                    cycle: cfg_cycle_i};

  smc_rd_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wr_idx_i (cfg_cs_i),
    .wr_i     (cfg_wr),
    .rd_idx_i (req_cs_i),
    .rd_o     (cfg_sel)
  );

  assign req_rdy_o = !tmr_act || tmr_last;
  assign accept    = req_i && req_rdy_o;

  // timing is frozen at acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      len_q  <= LEN_W'(1);
      cs_q   <= '0;
      addr_q <= '0;
    end else if (accept) begin
      cur_q  <= cfg_sel;
      len_q  <= eff_len(cfg_sel);
      cs_q   <= req_cs_i;
      addr_q <= req_addr_i;
    end
  end

  smc_rd_timer u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .len_i   (len_q),
    .act_o   (tmr_act),
    .cnt_o   (tmr_cnt),
    .last_o  (tmr_last)
  );

  smc_rd_window u_win_rd (
    .en_i    (tmr_act),
    .cnt_i   (tmr_cnt),
    .setup_i (cur_q.rd_setup),
    .pulse_i (cur_q.rd_pulse),
    .on_o    (rd_on),
    .end_o   (rd_end)
  );

  smc_rd_window u_win_cs (
    .en_i    (tmr_act),
    .cnt_i   (tmr_cnt),
    .setup_i (cur_q.cs_setup),
    .pulse_i (cur_q.cs_pulse),
    .on_o    (cs_on),
    .end_o   (cs_end)
  );

  assign mem_nrd_o  = !rd_on;
  assign mem_addr_o = addr_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ncs
    assign mem_ncs_o[g] = !(cs_on && (cs_q == IDX_W'(g)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      data_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      if (rd_end) cap_q <= mem_data_i;
      ack_q <= tmr_last;
      if (tmr_last) data_q <= rd_end ? mem_data_i : cap_q;
    end
  end

  assign rd_ack_o  = ack_q;
  assign rd_data_o = data_q;

  logic unused_cs_end;
  assign unused_cs_end = cs_end;

endmodule

// File: rtl/smc_rd_seq_chk.sv
module smc_rd_seq_chk
  import smc_rd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              act_i,
  input logic [LEN_W-1:0]  cnt_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              req_rdy_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [NUM_CS-1:0] mem_ncs_o,
  input logic              mem_nrd_o,
  input logic              rd_ack_o
);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |-> (mem_nrd_o && (&mem_ncs_o)));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (cnt_i < len_i));

  p_one_ncs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~mem_ncs_o) <= 1);

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_rdy_o |=> $stable(mem_addr_o));

  p_ack_after_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_o |-> ($past(act_i) && $past(req_rdy_o)));

endmodule

bind smc_rd_seq smc_rd_seq_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_i      (tmr_act),
  .cnt_i      (tmr_cnt),
  .len_i      (len_q),
  .req_rdy_o  (req_rdy_o),
  .mem_addr_o (mem_addr_o),
  .mem_ncs_o  (mem_ncs_o),
  .mem_nrd_o  (mem_nrd_o),
  .rd_ack_o   (rd_ack_o)
);

// File: tb/smc_rd_seq_test.sv
module smc_rd_seq_test;
  import smc_rd_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_cs_i = '0;
  logic [5:0]  cfg_rd_setup_i = '0, cfg_rd_pulse_i = '0;
  logic [5:0]  cfg_cs_setup_i = '0, cfg_cs_pulse_i = '0;
  logic [6:0]  cfg_cycle_i = '0;
  logic        req_i = 1'b0;
  logic [1:0]  req_cs_i = '0;
  logic [23:0] req_addr_i = '0;
  logic        req_rdy_o;
  logic [23:0] mem_addr_o;
  logic [3:0]  mem_ncs_o;
  logic        mem_nrd_o;
  logic [31:0] mem_data_i = '0;
  logic        rd_ack_o;
  logic [31:0] rd_data_o;

  smc_rd_seq uut (.*);

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;
  string phase = "R1";
  bit done = 0;

  // reference timing sets
  int m_rs[4], m_rp[4], m_cs[4], m_cp[4], m_cy[4];
  // running read
  bit  m_act = 0;
  int  m_cnt, m_len, c_rs, c_rp, c_cs, c_cp, m_sel;
  logic [23:0] m_addr = '0;
  logic [31:0] m_cap = '0, m_data = '0;
  bit  m_ack = 0;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) act=%h exp=%h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_rs[i] = 0; m_rp[i] = 1; m_cs[i] = 0; m_cp[i] = 1; m_cy[i] = 1;
    end
  end

  // reference model, updated at each edge from pre-edge values
  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit rdy, lst;
      lst = m_act && (m_cnt == m_len - 1);
      rdy = !m_act || lst;
      m_ack = 0;
      if (m_act) begin
        if (m_cnt == c_rs + c_rp - 1) m_cap = mem_data_i;
        if (lst) begin
          m_ack = 1; m_data = m_cap; m_act = 0;
        end else m_cnt++;
      end
      if (req_i && rdy) begin
        m_sel = req_cs_i;
        c_rs = m_rs[m_sel]; c_rp = m_rp[m_sel];
        c_cs = m_cs[m_sel]; c_cp = m_cp[m_sel];
        m_len = imax(m_cy[m_sel], imax(c_rs + c_rp, c_cs + c_cp));
        m_act = 1; m_cnt = 0; m_addr = req_addr_i;
      end
      if (cfg_we_i) begin
        m_rs[cfg_cs_i] = cfg_rd_setup_i;
        m_rp[cfg_cs_i] = (cfg_rd_pulse_i == 0) ? 1 : cfg_rd_pulse_i;
        m_cs[cfg_cs_i] = cfg_cs_setup_i;
        m_cp[cfg_cs_i] = (cfg_cs_pulse_i == 0) ? 1 : cfg_cs_pulse_i;
        m_cy[cfg_cs_i] = cfg_cycle_i;
      end
    end
  end

  // compare at the falling edge; fresh data word every clock
  always @(negedge clk_i) begin
    mem_data_i <= $urandom;
    if (rst_ni && !done) begin
      logic e_nrd; logic [3:0] e_ncs; logic e_rdy;
      e_nrd = !(m_act && m_cnt >= c_rs && m_cnt < c_rs + c_rp);
      e_ncs = 4'hF;
      if (m_act && m_cnt >= c_cs && m_cnt < c_cs + c_cp) e_ncs[m_sel] = 1'b0;
      e_rdy = !m_act || (m_cnt == m_len - 1);
      check(mem_nrd_o == e_nrd, "R3 read strobe", 32'(mem_nrd_o), 32'(e_nrd));
      check(mem_ncs_o == e_ncs, "R4 chip select", 32'(mem_ncs_o), 32'(e_ncs));
      check(req_rdy_o == e_rdy, "R2 ready/length", 32'(req_rdy_o), 32'(e_rdy));
      check(rd_ack_o == m_ack, "R6 ack", 32'(rd_ack_o), 32'(m_ack));
      if (m_act) check(mem_addr_o == m_addr, "R5 address", 32'(mem_addr_o), 32'(m_addr));
      if (m_ack) check(rd_data_o == m_data, "R6 data", rd_data_o, m_data);
    end
  end

  task automatic cfg_write(int cs, int rs, int rp, int ss, int sp, int cy);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_cs_i = 2'(cs);
    cfg_rd_setup_i = 6'(rs); cfg_rd_pulse_i = 6'(rp);
    cfg_cs_setup_i = 6'(ss); cfg_cs_pulse_i = 6'(sp); cfg_cycle_i = 7'(cy);
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  // offer a request; held while ready is low, returns after the accepting edge
  task automatic issue(int cs, logic [23:0] a);
    req_i = 1; req_cs_i = 2'(cs); req_addr_i = a;
    while (!req_rdy_o) @(negedge clk_i);
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic drain();
    while (!req_rdy_o || m_act) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 190000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    phase = "R1";
    check(mem_nrd_o === 1'b1, "R1 nrd idle", 32'(mem_nrd_o), 1);
    check(mem_ncs_o === 4'hF, "R1 ncs idle", 32'(mem_ncs_o), 32'hF);
    check(rd_ack_o === 1'b0, "R1 ack idle", 32'(rd_ack_o), 0);
    check(req_rdy_o === 1'b1, "R1 ready idle", 32'(req_rdy_o), 1);

    phase = "R2 default timing";
    issue(2, 24'h000123); drain();

    phase = "R7 per-cs sets";
    cfg_write(0, 2, 3, 1, 5, 8);
    cfg_write(1, 0, 4, 0, 4, 4);
    cfg_write(2, 5, 6, 0, 2, 3);
    cfg_write(3, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      issue(i, 24'h100000 + 24'(i)); drain();
    end

    phase = "R10 stretched cycle";
    issue(2, 24'h0AAAAA); issue(2, 24'h0BBBBB); drain();

    phase = "R9 gapless burst";
    nb = 0;
    issue(1, 24'h000010);
    for (int i = 1; i < 5; i++) begin
      fork
        issue(1, 24'h000010 + 24'(i));
        begin
          @(negedge clk_i);
          while (req_i) begin
            if (mem_nrd_o || mem_ncs_o[1]) nb++;
            @(negedge clk_i);
          end
        end
      join
    end
    check(nb == 0, "R9 strobe gap count", nb, 0);
    drain();

    phase = "R8 write during read";
    issue(0, 24'h0C0C0C);
    cfg_write(0, 0, 1, 0, 1, 2);
    drain();
    issue(0, 24'h0D0D0D); drain();

    phase = "R11 held request";
    issue(3, 24'h00E000); issue(0, 24'h00E001); issue(3, 24'h00E002); drain();

    phase = "random";
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 250; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 9) == 0)
          cfg_write($urandom_range(0, 3), $urandom_range(0, 63), $urandom_range(0, 63),
                    $urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 127));
        else
          cfg_write($urandom_range(0, 3), $urandom_range(0, 4), $urandom_range(0, 5),
                    $urandom_range(0, 4), $urandom_range(0, 5), $urandom_range(0, 12));
      end
      issue($urandom_range(0, 3), 24'($urandom));
      if ($urandom_range(0, 2) == 0) drain();
    end
    drain();
    finish_run();
  end

endmodule